// File: doc/BRIEF.md
# Reference Frame Buffer Manager

This block keeps track of a fixed pool of frame buffers that live in external memory on behalf of a video decoder. When the decoder begins a frame it asks for a buffer and gets back the base address of the lowest-numbered free one. When the frame is finished, the buffer is queued for display and, if the frame will be used for prediction, it is appended to the reference list. A display client pulls frames from the head of that queue and may show each one several times, so that slow content can fill a faster output. Motion compensation turns a reference index into a base address with a one-cycle lookup.

A base-address table is loaded at run time, which is how a change of picture size is absorbed. A per-slot state table records whether each slot is in use, waiting for display, or referenced, together with the entry of the base-address table it maps to. One central engine serves one request at a time, and display requests always win. A slot goes back to the free pool only when display has finished with it and it has left the reference list. Allocation and removal from the reference list walk the tables one entry per cycle, so each takes at most 16 cycles.

Top module: `refbuf_manager`

## Requirements
- R1: Writing base-address table entry s with `tbl_we` makes s's address the one that is reported whenever slot s is later allocated, displayed or looked up.
- R2: A granted allocation returns, with a one-cycle `alloc_ack` pulse, the base address of the lowest-numbered free slot in `alloc_ptr`. That slot becomes the current decode slot.
- R3: While every slot is in use, a held `alloc_req` receives no acknowledge.
- R4: An insertion pulses `ins_ack` and places the current decode slot at the tail of the display queue. If `ins_is_ref` is 1, the slot is also appended to the end of the reference list.
- R5: Each acknowledged `disp_req` returns in `disp_ptr` the base address of the frame at the head of the display queue. A frame is returned `disp_rpt` times in a row (a value of 0 counts as 1) before the queue moves on. When the display queue is empty, `disp_req` waits without an acknowledge.
- R6: When requests arrive together, display is served first, then reference removal, then insertion, then allocation.
- R7: `drop_req` with index k below the reference count removes entry k, and every later entry moves down one place. An index at or above the count is acknowledged and changes nothing.
- R8: A slot returns to the free pool only when it is no longer waiting for display and is not in the reference list, whichever of the two happens last.
- R9: `mc_ptr` shows, one cycle after `mc_idx` is applied, the base address of reference entry `mc_idx`. It shows 0 if the index is at or beyond the reference count.
- R10: The reference count never exceeds the pool size and changes by at most one per cycle.
- R11: After reset all acknowledges are low and the reference list is empty; at most one acknowledge is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Base-address table write enable |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_ptr | input | PTR_W | Base address to write |
| alloc_req | input | 1 | Decoder asks for a buffer (held until ack) |
| alloc_ack | output | 1 | Allocation done |
| alloc_ptr | output | PTR_W | Base address of allocated buffer |
| ins_req | input | 1 | Decoder finished the current frame (held until ack) |
| ins_is_ref | input | 1 | Finished frame is a reference |
| ins_ack | output | 1 | Insertion done |
| disp_req | input | 1 | Display asks for the next frame to show |
| disp_rpt | input | RPT_W | Times each frame is shown |
| disp_ack | output | 1 | Display request served |
| disp_ptr | output | PTR_W | Base address of frame to show |
| drop_req | input | 1 | Remove an entry from the reference list |
| drop_idx | input | IDX_W | Reference index to remove |
| drop_ack | output | 1 | Removal done |
| mc_idx | input | IDX_W | Reference index to look up |
| mc_ptr | output | PTR_W | Base address of that reference, one cycle later |

## Verification
The hardest state to reach is a slot whose display has finished while it is still in the reference list, or the reverse. Such a slot must stay out of the free pool until both conditions clear. The bench first fills all 16 slots with a mixed pattern of reference and non-reference frames. It then raises a display request and a removal request in the same cycle, which also exercises the priority order. After that it asks for allocation and shows that the slot just dropped from the reference list is skipped while it still awaits display, and is granted only after its final repeat has been shown.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_DISP,
        OP_DROP,
        OP_INS,
        OP_ALLOC
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SHIFT
    } eng_e;

    typedef struct packed {
        logic used;
        logic shown_pend;
        logic in_ref;
    } slot_flags_t;

    function automatic slot_flags_t flags_clear();
        slot_flags_t f;
        f.used       = 1'b0;
        f.shown_pend = 1'b0;
        f.in_ref     = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/fbm_ptr_table.sv
module fbm_ptr_table #(
    parameter int NBUF  = 16,
    parameter int PTR_W = 32,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [IDX_W-1:0] a_idx,
    output logic [PTR_W-1:0] a_ptr,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             b_en,
    output logic [PTR_W-1:0] b_ptr
);
    logic [PTR_W-1:0] mem [NBUF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_ptr;
        end
    end

    assign a_ptr = mem[a_idx];

    always_ff @(posedge clk) begin
        if (rst) b_ptr <= '0;
        else     b_ptr <= b_en ? mem[b_idx] : '0;
    end
endmodule

// File: rtl/fbm_disp_queue.sv
module fbm_disp_queue #(
    parameter int NBUF  = 16,
    parameter int RPT_W = 4,
    localparam int IDX_W = $clog2(NBUF),
    localparam int CNT_W = $clog2(NBUF + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [IDX_W-1:0] push_slot,
    input  logic             show,
    input  logic [RPT_W-1:0] rpt,
    output logic [IDX_W-1:0] head,
    output logic             empty,
    output logic             last
);
    logic [IDX_W-1:0] slots [NBUF];
    logic [IDX_W-1:0] rd_p, wr_p;
    logic [CNT_W-1:0] count;
    logic [RPT_W-1:0] shows;
    logic [RPT_W-1:0] eff_rpt;

    assign eff_rpt = (rpt == '0) ? RPT_W'(1) : rpt;
    assign head    = slots[rd_p];
    assign empty   = (count == '0);
    assign last    = ({1'b0, shows} + 1'b1) >= {1'b0, eff_rpt};

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= '0;
            shows <= '0;
            for (int i = 0; i < NBUF; i++) slots[i] <= '0;
        end else begin
            if (push) begin
                slots[wr_p] <= push_slot;
                wr_p        <= wr_p + 1'b1;
            end
            if (show) begin
                if (last) begin
                    shows <= '0;
                    rd_p  <= rd_p + 1'b1;
                end else begin
                    shows <= shows + 1'b1;
                end
            end
            if (push && !(show && last))      count <= count + 1'b1;
            else if (!push && show && last)   count <= count - 1'b1;
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(NBUF)));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        show |-> !empty);
endmodule

// File: rtl/fbm_arb.sv
module fbm_arb
    import fbm_pkg::*;
(
    input  logic disp_ok,
    input  logic drop_ok,
    input  logic ins_ok,
    input  logic alloc_ok,
    output op_e  op
);
    always_comb begin
        if (disp_ok)       op = OP_DISP;
        else if (drop_ok)  op = OP_DROP;
        else if (ins_ok)   op = OP_INS;
        else if (alloc_ok) op = OP_ALLOC;
        else               op = OP_NONE;
    end
endmodule

// File: rtl/refbuf_manager.sv
module refbuf_manager
    import fbm_pkg::*;
#(
    parameter int NBUF  = 16,
    parameter int PTR_W = 32,
    parameter int RPT_W = 4,
    localparam int IDX_W = $clog2(NBUF),
    localparam int CNT_W = $clog2(NBUF + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [PTR_W-1:0] tbl_ptr,
    input  logic             alloc_req,
    output logic             alloc_ack,
    output logic [PTR_W-1:0] alloc_ptr,
    input  logic             ins_req,
    input  logic             ins_is_ref,
    output logic             ins_ack,
    input  logic             disp_req,
    input  logic [RPT_W-1:0] disp_rpt,
    output logic             disp_ack,
    output logic [PTR_W-1:0] disp_ptr,
    input  logic             drop_req,
    input  logic [IDX_W-1:0] drop_idx,
    output logic             drop_ack,
    input  logic [IDX_W-1:0] mc_idx,
    output logic [PTR_W-1:0] mc_ptr
);
    slot_flags_t      flags [NBUF];
    logic [IDX_W-1:0] pidx  [NBUF];
    logic [IDX_W-1:0] rlist [NBUF];
    logic [CNT_W-1:0] ref_cnt;
    logic [IDX_W-1:0] dec_slot;
    logic [IDX_W-1:0] scan;
    eng_e             st;

    logic [NBUF-1:0]  free_vec;
    logic             any_free;
    op_e              op;
    logic             idle;
    logic [IDX_W-1:0] q_head;
    logic             q_empty, q_last;
    logic             q_push, q_show;
    logic [IDX_W-1:0] rd_slot;
    logic [PTR_W-1:0] a_ptr;
    logic [IDX_W-1:0] victim;
    logic             drop_in_range;
    logic             mc_in_range;

    for (genvar g = 0; g < NBUF; g++) begin : g_free
        assign free_vec[g] = !flags[g].used;
    end
    assign any_free = |free_vec;

    assign idle          = (st == ST_IDLE);
    assign victim        = rlist[drop_idx];
    assign drop_in_range = (CNT_W'(drop_idx) < ref_cnt);
    assign mc_in_range   = (CNT_W'(mc_idx) < ref_cnt);
    assign rd_slot       = (st == ST_SCAN) ? scan : q_head;

    fbm_arb u_arb (
        .disp_ok  (idle && disp_req && !q_empty),
        .drop_ok  (idle && drop_req),
        .ins_ok   (idle && ins_req),
        .alloc_ok (idle && alloc_req && any_free),
        .op       (op)
    );

    assign q_push = (op == OP_INS);
    assign q_show = (op == OP_DISP);

    fbm_disp_queue #(.NBUF(NBUF), .RPT_W(RPT_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_slot (dec_slot),
        .show      (q_show),
        .rpt       (disp_rpt),
        .head      (q_head),
        .empty     (q_empty),
        .last      (q_last)
    );

    fbm_ptr_table #(.NBUF(NBUF), .PTR_W(PTR_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .wr_idx (tbl_idx),
        .wr_ptr (tbl_ptr),
        .a_idx  (pidx[rd_slot]),
        .a_ptr  (a_ptr),
        .b_idx  (pidx[rlist[mc_idx]]),
        .b_en   (mc_in_range),
        .b_ptr  (mc_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) begin
                flags[i] <= flags_clear();
                pidx[i]  <= IDX_W'(i);
                rlist[i] <= '0;
            end
            ref_cnt   <= '0;
            dec_slot  <= '0;
            scan      <= '0;
            st        <= ST_IDLE;
            alloc_ack <= 1'b0;
            ins_ack   <= 1'b0;
            disp_ack  <= 1'b0;
            drop_ack  <= 1'b0;
            alloc_ptr <= '0;
            disp_ptr  <= '0;
        end else begin
            alloc_ack <= 1'b0;
            ins_ack   <= 1'b0;
            disp_ack  <= 1'b0;
            drop_ack  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    case (op)
                        OP_DISP: begin
                            disp_ack <= 1'b1;
                            disp_ptr <= a_ptr;
                            if (q_last) begin
                                flags[q_head].shown_pend <= 1'b0;
                                if (!flags[q_head].in_ref) flags[q_head].used <= 1'b0;
                            end
                        end
                        OP_DROP: begin
                            if (drop_in_range) begin
                                flags[victim].in_ref <= 1'b0;
                                if (!flags[victim].shown_pend) flags[victim].used <= 1'b0;
                                scan <= drop_idx;
                                st   <= ST_SHIFT;
                            end else begin
                                drop_ack <= 1'b1;
                            end
                        end
                        OP_INS: begin
                            flags[dec_slot].shown_pend <= 1'b1;
                            if (ins_is_ref) begin
                                flags[dec_slot].in_ref          <= 1'b1;
                                rlist[ref_cnt[IDX_W-1:0]] <= dec_slot;
                                ref_cnt                    <= ref_cnt + 1'b1;
                            end
                            ins_ack <= 1'b1;
                        end
                        OP_ALLOC: begin
                            scan <= '0;
                            st   <= ST_SCAN;
                        end
                        default: ;
                    endcase
                end
                ST_SCAN: begin
                    if (free_vec[scan]) begin
                        flags[scan].used <= 1'b1;
                        dec_slot  <= scan;
                        alloc_ptr <= a_ptr;
                        alloc_ack <= 1'b1;
                        st        <= ST_IDLE;
                    end else begin
                        scan <= scan + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if ((CNT_W'(scan) + 1'b1) < ref_cnt) begin
                        rlist[scan] <= rlist[scan + 1'b1];
                        scan        <= scan + 1'b1;
                    end else begin
                        ref_cnt  <= ref_cnt - 1'b1;
                        drop_ack <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_one_ack_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({alloc_ack, ins_ack, disp_ack, drop_ack}));

    p_refcnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        ref_cnt <= CNT_W'(NBUF));

    p_refcnt_step_r10: assert property (@(posedge clk) disable iff (rst)
        (ref_cnt != $past(ref_cnt)) |->
            ((ref_cnt == $past(ref_cnt) + 1'b1) || (ref_cnt + 1'b1 == $past(ref_cnt))));

    p_alloc_has_free_r3: assert property (@(posedge clk) disable iff (rst)
        alloc_ack |-> $past(any_free));

    p_disp_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        disp_ack |-> $past(!q_empty));

    p_ins_room_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INS && ins_is_ref) |-> (ref_cnt < CNT_W'(NBUF)));

    p_disp_first_r6: assert property (@(posedge clk) disable iff (rst)
        (idle && disp_req && !q_empty) |=> disp_ack);
endmodule

// File: tb/refbuf_manager_bench.sv
module refbuf_manager_bench;
    localparam int NBUF  = 16;
    localparam int PTR_W = 32;
    localparam int RPT_W = 4;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tbl_we = 1'b0;
    logic [IDX_W-1:0] tbl_idx = '0;
    logic [PTR_W-1:0] tbl_ptr = '0;
    logic             alloc_req = 1'b0;
    logic             alloc_ack;
    logic [PTR_W-1:0] alloc_ptr;
    logic             ins_req = 1'b0;
    logic             ins_is_ref = 1'b0;
    logic             ins_ack;
    logic             disp_req = 1'b0;
    logic [RPT_W-1:0] disp_rpt = '0;
    logic             disp_ack;
    logic [PTR_W-1:0] disp_ptr;
    logic             drop_req = 1'b0;
    logic [IDX_W-1:0] drop_idx = '0;
    logic             drop_ack;
    logic [IDX_W-1:0] mc_idx = '0;
    logic [PTR_W-1:0] mc_ptr;

    always #4 clk = ~clk;

    refbuf_manager #(.NBUF(NBUF), .PTR_W(PTR_W), .RPT_W(RPT_W)) u_refbuf_manager (
        .clk(clk), .rst(rst),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_ptr(tbl_ptr),
        .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_ptr(alloc_ptr),
        .ins_req(ins_req), .ins_is_ref(ins_is_ref), .ins_ack(ins_ack),
        .disp_req(disp_req), .disp_rpt(disp_rpt), .disp_ack(disp_ack), .disp_ptr(disp_ptr),
        .drop_req(drop_req), .drop_idx(drop_idx), .drop_ack(drop_ack),
        .mc_idx(mc_idx), .mc_ptr(mc_ptr)
    );

    int checks = 0;
    int errors = 0;

    // Bench model of the pool
    bit m_used [NBUF];
    bit m_disp [NBUF];
    bit m_ref  [NBUF];
    int rl [NBUF];
    int rlc = 0;
    int dq [NBUF];
    int dq_h = 0;
    int dq_n = 0;
    int shows = 0;
    int cur = 0;

    function automatic logic [PTR_W-1:0] pv(int s);
        return 32'h8000_0000 + s * 32'h0004_0000 + s;
    endfunction

    function automatic int lowest_free();
        for (int s = 0; s < NBUF; s++) if (!m_used[s]) return s;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [PTR_W-1:0] act,
                       input logic [PTR_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_alloc();
        int n = 0;
        int s = lowest_free();
        alloc_req = 1'b1;
        do begin @(negedge clk); n++; end while (!alloc_ack && n < 100);
        chk(alloc_ack, "R2 alloc ack", {31'b0, alloc_ack}, 1);
        chk(alloc_ptr == pv(s), "R2 R1 alloc lowest free ptr", alloc_ptr, pv(s));
        alloc_req = 1'b0;
        m_used[s] = 1; cur = s;
    endtask

    task automatic do_ins(input bit r);
        int n = 0;
        ins_req = 1'b1; ins_is_ref = r;
        do begin @(negedge clk); n++; end while (!ins_ack && n < 100);
        chk(ins_ack, "R4 insert ack", {31'b0, ins_ack}, 1);
        ins_req = 1'b0;
        m_disp[cur] = 1;
        dq[(dq_h + dq_n) % NBUF] = cur; dq_n++;
        if (r) begin m_ref[cur] = 1; rl[rlc] = cur; rlc++; end
    endtask

    task automatic model_show(input int rpt);
        int s = dq[dq_h];
        int eff = (rpt == 0) ? 1 : rpt;
        shows++;
        if (shows >= eff) begin
            shows = 0; dq_h = (dq_h + 1) % NBUF; dq_n--;
            m_disp[s] = 0;
            if (!m_ref[s]) m_used[s] = 0;
        end
    endtask

    task automatic do_disp(input int rpt);
        int n = 0;
        logic [PTR_W-1:0] e = pv(dq[dq_h]);
        disp_req = 1'b1; disp_rpt = RPT_W'(rpt);
        do begin @(negedge clk); n++; end while (!disp_ack && n < 100);
        chk(disp_ack && disp_ptr == e, "R5 display head frame", disp_ptr, e);
        disp_req = 1'b0;
        model_show(rpt);
    endtask

    task automatic model_drop(input int k);
        if (k < rlc) begin
            int s = rl[k];
            for (int j = k; j < rlc - 1; j++) rl[j] = rl[j + 1];
            rlc--;
            m_ref[s] = 0;
            if (!m_disp[s]) m_used[s] = 0;
        end
    endtask

    task automatic do_drop(input int k);
        int n = 0;
        drop_req = 1'b1; drop_idx = IDX_W'(k);
        do begin @(negedge clk); n++; end while (!drop_ack && n < 100);
        chk(drop_ack, "R7 drop ack", {31'b0, drop_ack}, 1);
        drop_req = 1'b0;
        model_drop(k);
    endtask

    task automatic mc_sweep();
        for (int i = 0; i < NBUF; i++) begin
            logic [PTR_W-1:0] e = (i < rlc) ? pv(rl[i]) : '0;
            mc_idx = IDX_W'(i);
            @(negedge clk);
            chk(mc_ptr == e, "R9 R7 reference lookup", mc_ptr, e);
        end
    endtask

    task automatic expect_no_alloc(input string req);
        bit seen = 0;
        alloc_req = 1'b1;
        repeat (40) begin @(negedge clk); if (alloc_ack) seen = 1; end
        chk(!seen, req, {31'b0, seen}, 0);
        alloc_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NBUF; s++) begin m_used[s] = 0; m_disp[s] = 0; m_ref[s] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk({alloc_ack, ins_ack, disp_ack, drop_ack} == 4'b0, "R11 acks low after reset",
            {28'b0, alloc_ack, ins_ack, disp_ack, drop_ack}, 0);
        chk(mc_ptr == '0, "R11 R9 empty list lookup", mc_ptr, 0);

        // R1 table load
        for (int s = 0; s < NBUF; s++) begin
            tbl_we = 1'b1; tbl_idx = IDX_W'(s); tbl_ptr = pv(s);
            @(negedge clk);
        end
        tbl_we = 1'b0;

        // Fill the pool, R2 R4
        for (int i = 0; i < NBUF; i++) begin
            do_alloc();
            do_ins(i % 3 != 0);
        end
        mc_sweep();

        // R3 pool full
        expect_no_alloc("R3 no grant while pool full");

        // R6 simultaneous display and drop: display first
        begin
            int n = 0;
            logic [PTR_W-1:0] e = pv(dq[dq_h]);
            bit disp_first;
            disp_req = 1'b1; disp_rpt = 4'd1;
            drop_req = 1'b1; drop_idx = '0;
            do begin @(negedge clk); n++; end while (!disp_ack && !drop_ack && n < 100);
            disp_first = disp_ack && !drop_ack;
            chk(disp_first, "R6 display served before drop", {31'b0, disp_first}, 1);
            chk(disp_ptr == e, "R5 display head under contention", disp_ptr, e);
            disp_req = 1'b0;
            model_show(1);
            n = 0;
            while (!drop_ack && n < 100) begin @(negedge clk); n++; end
            chk(drop_ack, "R6 drop served after display", {31'b0, drop_ack}, 1);
            drop_req = 1'b0;
            model_drop(0);
        end
        mc_sweep();

        // R8: slot 0 freed (not reference), slot 1 dropped but still awaiting display
        do_alloc();
        expect_no_alloc("R8 dropped slot held until displayed");
        do_ins(1'b1);

        // Drain display with varied repeat counts, R5
        for (int k = 0; dq_n > 0; k++) begin
            int rpt = k % 4;
            int eff = (rpt == 0) ? 1 : rpt;
            for (int r = 0; r < eff; r++) do_disp(rpt);
        end

        // R5 empty queue waits
        begin
            bit seen = 0;
            disp_req = 1'b1;
            repeat (30) begin @(negedge clk); if (disp_ack) seen = 1; end
            chk(!seen, "R5 display waits on empty queue", {31'b0, seen}, 0);
            disp_req = 1'b0;
            @(negedge clk);
        end

        // R8: slot 1 now free; reference slots stay used
        do_alloc();
        do_ins(1'b0);
        do_disp(0);

        // R7 removals
        do_drop(rlc);
        mc_sweep();
        do_drop(rlc / 2);
        mc_sweep();
        do_drop(rlc - 1);
        mc_sweep();
        do_drop(0);
        mc_sweep();

        // R8: dropped displayed references return to pool in slot order
        for (int i = 0; i < 4; i++) begin
            do_alloc();
            do_ins(i[0]);
        end
        mc_sweep();
        while (rlc > 0) do_drop(0);
        mc_sweep();
        while (dq_n > 0) do_disp(2);
        for (int i = 0; i < NBUF; i++) begin
            if (lowest_free() < 0) break;
            do_alloc();
        end
        expect_no_alloc("R3 full again after refill");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule